// File: doc/BRIEF.md
# Sample Phase Tuning Sweep Controller

This controller searches for a receive sample phase that a high-speed card link can use reliably. It steps a sample clock across a set of phase positions around the clock period. For each position it shows the phase on its output, pulses an apply strobe, and then asks an external command engine to run one tuning transfer. The engine answers with a done pulse and a pass bit. After the sweep, the controller groups consecutive passing positions into runs. It joins a run that touches both ends of the sweep, picks the longest run, and applies the phase at the centre of that run.

Positions above 270 degrees are never tried. A centre that still falls beyond 270 degrees after wrap-around is pulled back to 270 or forward to 0, whichever edge of the excluded band is closer. When no position passes, the controller reports an error and leaves the phase untouched. The delay line that realises a phase and the protocol of the tuning transfer both sit outside this block.

Top module: `sample_phase_tuner`

## Requirements
- R1: After a synchronous reset, busy, done, error, tuneReq and phaseApply are low, and finalPhase and phaseOut are 0.
- R2: Step i stands for the phase ceil(i*360/32) degrees. The sweep tries steps 0 to 24 in rising order (0 to 270 degrees) and stops before the first step above 270, so exactly 25 steps are applied.
- R3: For each step, phaseApply is high for exactly one cycle with phaseOut holding that step's phase. tuneReq then stays high until tuneDone is seen, and tunePass is latched in that cycle. phaseApply and tuneReq are never high together.
- R4: Each change from fail to pass opens a new run. The result before step 0 counts as a fail, so a pass at step 0 opens a run. Each passing step moves the end of the current run forward.
- R5: If no step passes, the controller raises done for one cycle with error high and does not pulse phaseApply after the sweep.
- R6: If there are two or more runs and both step 0 and step 24 passed, the last run is merged into the first. The merged run starts at the last run's start and keeps the first run's end.
- R7: A run's length is end - start + 1, plus 32 if that is negative. The longest run is selected, and the earliest run wins a tie.
- R8: The chosen step is (start + length/2) mod 32, using integer division, converted to degrees as in R2.
- R9: If the chosen phase is above 270, it becomes 270 when it is below 315 and 0 otherwise. finalPhase never exceeds 270.
- R10: On success the controller puts the chosen phase on phaseOut with one more phaseApply pulse, then raises done for one cycle with error low and finalPhase equal to that phase.
- R11: A start pulse while busy is high is ignored: the sweep continues without restarting, and exactly 26 applies occur on success.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Begin a tuning sweep (accepted only when idle) |
| tuneDone | input | 1 | Tuning transfer finished |
| tunePass | input | 1 | Result of the transfer, valid with tuneDone |
| tuneReq | output | 1 | Request one tuning transfer |
| phaseApply | output | 1 | One-cycle strobe to load phaseOut into the delay line |
| phaseOut | output | 9 | Phase in degrees to apply |
| busy | output | 1 | A sweep or selection is in progress |
| done | output | 1 | One-cycle completion pulse |
| error | output | 1 | No passing phase in the last sweep |
| finalPhase | output | 9 | Selected phase in degrees |

## Verification
The hardest states to reach are the wrap-around merge and the two clamp outcomes. Both need pass patterns that pass at the first and last tested steps while failing in between, and a merged run long enough to push its centre past 270 degrees. Directed patterns aim at each outcome: a centre landing at step 25 (clamped to 270) and one at step 28 (clamped to 0). A tie between runs of equal length and the all-fail and all-pass cases are also directed. Random pass patterns from a seeded generator, with random engine latency and a stray start pulse injected mid-sweep, are compared against a reference model in the bench.

// File: rtl/sweep_pkg.sv
package sweep_pkg;

  typedef struct packed {
    logic clear;
    logic record;
    logic advance;
    logic merge;
    logic scan;
    logic pick;
    logic selFinal;
  } ctrlStrobes_t;

  typedef struct packed {
    logic sweepLast;
    logic noRuns;
    logic scanLast;
  } sweepStatus_t;

  function automatic int stepToDeg(input int idx, input int steps);
    return (idx * 360 + steps - 1) / steps;
  endfunction

endpackage

// File: rtl/sweep_datapath.sv
module sweep_datapath
  import sweep_pkg::*;
#(
  parameter int NSTEPS   = 32,
  parameter int MAX_DEG  = 270,
  parameter int MAX_RUNS = 17,
  parameter int DEGW     = 9
) (
  input  logic                clk,
  input  logic                rst,
  input  ctrlStrobes_t        ctl,
  input  logic                tunePass,
  output sweepStatus_t        stat,
  output logic [DEGW-1:0]     phaseOut,
  output logic [DEGW-1:0]     finalPhase
);
  localparam int IDXW        = $clog2(NSTEPS);
  localparam int CW          = $clog2(MAX_RUNS + 1);
  localparam int CLAMP_SPLIT = (MAX_DEG + 360) / 2;

  logic [IDXW-1:0] step;
  logic            prevPass, firstPass, lastPass;
  logic [CW-1:0]   runCount;
  logic [IDXW-1:0] runStart [MAX_RUNS];
  logic [IDXW-1:0] runEnd   [MAX_RUNS];
  logic [CW-1:0]   scanIdx;
  logic [IDXW:0]   bestLen;
  logic [IDXW-1:0] bestStart;

  logic [IDXW:0]   curLen;
  logic [DEGW-1:0] stepDeg, pickDeg;
  logic            doFold;

  // Degree value of the current sweep step and the sweep-end test
  always_comb begin
    int sd, nd;
    sd = stepToDeg(int'(step), NSTEPS);
    nd = stepToDeg(int'(step) + 1, NSTEPS);
    stepDeg        = DEGW'(sd);
    stat.sweepLast = (nd > MAX_DEG) || (int'(step) == NSTEPS - 1);
  end

  assign stat.noRuns   = (runCount == '0);
  assign stat.scanLast = (scanIdx == runCount - 1'b1);
  assign doFold        = (runCount > CW'(1)) && firstPass && lastPass;
  assign phaseOut      = ctl.selFinal ? finalPhase : stepDeg;

  // Length of the run under the scan pointer, with wrap correction
  always_comb begin
    int rawLen;
    rawLen = int'(runEnd[scanIdx]) - int'(runStart[scanIdx]) + 1;
    if (rawLen < 0) rawLen = rawLen + NSTEPS;
    curLen = (IDXW+1)'(rawLen);
  end

  // Centre of the best run, converted and clamped
  always_comb begin
    int midStep, midDeg;
    midStep = (int'(bestStart) + int'(bestLen) / 2) % NSTEPS;
    midDeg  = stepToDeg(midStep, NSTEPS);
    if (midDeg > MAX_DEG) midDeg = (midDeg < CLAMP_SPLIT) ? MAX_DEG : 0;
    pickDeg = DEGW'(midDeg);
  end

  always_ff @(posedge clk) begin
    if (rst || ctl.clear) begin
      step      <= '0;
      prevPass  <= 1'b0;
      firstPass <= 1'b0;
      lastPass  <= 1'b0;
      runCount  <= '0;
    end else begin
      if (ctl.record) begin
        if (step == '0) firstPass <= tunePass;
        lastPass <= tunePass;
        prevPass <= tunePass;
        if (tunePass && !prevPass) begin
          runStart[runCount] <= step;
          runEnd[runCount]   <= step;
          runCount           <= runCount + 1'b1;
        end else if (tunePass) begin
          runEnd[runCount - 1'b1] <= step;
        end
      end
      if (ctl.advance) step <= step + 1'b1;
      if (ctl.merge && doFold) begin
        runStart[0] <= runStart[runCount - 1'b1];
        runCount    <= runCount - 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      scanIdx    <= '0;
      bestLen    <= '0;
      bestStart  <= '0;
      finalPhase <= '0;
    end else begin
      if (ctl.merge) begin
        scanIdx <= '0;
        bestLen <= '0;
      end
      if (ctl.scan) begin
        scanIdx <= scanIdx + 1'b1;
        if (curLen > bestLen) begin
          bestLen   <= curLen;
          bestStart <= runStart[scanIdx];
        end
      end
      if (ctl.pick) finalPhase <= pickDeg;
    end
  end

  // R4
  run_table_bound_chk: assert property (@(posedge clk) disable iff (rst)
    runCount <= CW'(MAX_RUNS));

  // R6
  merge_shrinks_chk: assert property (@(posedge clk) disable iff (rst)
    ctl.merge |=> runCount <= $past(runCount));

  // R9
  final_in_band_chk: assert property (@(posedge clk) disable iff (rst)
    finalPhase <= DEGW'(MAX_DEG));

  // R2
  sweep_phase_band_chk: assert property (@(posedge clk) disable iff (rst)
    ctl.record |-> stepDeg <= DEGW'(MAX_DEG));

endmodule

// File: rtl/sweep_control.sv
module sweep_control
  import sweep_pkg::*;
(
  input  logic         clk,
  input  logic         rst,
  input  logic         start,
  input  logic         tuneDone,
  input  sweepStatus_t stat,
  output ctrlStrobes_t ctl,
  output logic         tuneReq,
  output logic         phaseApply,
  output logic         busy,
  output logic         done,
  output logic         error
);
  typedef enum logic [2:0] {
    S_IDLE, S_APPLY, S_WAIT, S_MERGE, S_SCAN, S_PICK, S_FAPPLY, S_FIN
  } state_t;

  state_t state, nextState;

  always_comb begin
    nextState    = state;
    ctl          = '0;
    tuneReq      = 1'b0;
    phaseApply   = 1'b0;
    ctl.selFinal = (state == S_IDLE) || (state == S_FAPPLY) || (state == S_FIN);
    unique case (state)
      S_IDLE: if (start) begin
        ctl.clear = 1'b1;
        nextState = S_APPLY;
      end
      S_APPLY: begin
        phaseApply = 1'b1;
        nextState  = S_WAIT;
      end
      S_WAIT: begin
        tuneReq = 1'b1;
        if (tuneDone) begin
          ctl.record = 1'b1;
          if (stat.sweepLast) nextState = S_MERGE;
          else begin
            ctl.advance = 1'b1;
            nextState   = S_APPLY;
          end
        end
      end
      S_MERGE: begin
        if (stat.noRuns) nextState = S_FIN;
        else begin
          ctl.merge = 1'b1;
          nextState = S_SCAN;
        end
      end
      S_SCAN: begin
        ctl.scan = 1'b1;
        if (stat.scanLast) nextState = S_PICK;
      end
      S_PICK: begin
        ctl.pick  = 1'b1;
        nextState = S_FAPPLY;
      end
      S_FAPPLY: begin
        phaseApply = 1'b1;
        nextState  = S_FIN;
      end
      S_FIN:   nextState = S_IDLE;
      default: nextState = S_IDLE;
    endcase
  end

  assign busy = (state != S_IDLE);
  assign done = (state == S_FIN);

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= S_IDLE;
      error <= 1'b0;
    end else begin
      state <= nextState;
      if (state == S_IDLE && start) error <= 1'b0;
      else if (state == S_MERGE && stat.noRuns) error <= 1'b1;
    end
  end

  // R3
  apply_req_excl_chk: assert property (@(posedge clk) disable iff (rst)
    !(phaseApply && tuneReq));

  // R3
  apply_single_chk: assert property (@(posedge clk) disable iff (rst)
    phaseApply |=> !phaseApply);

  // R10
  done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    done |=> !done && !busy);

  // R11
  busy_hold_chk: assert property (@(posedge clk) disable iff (rst)
    busy && !done |=> busy);

  // R5
  err_no_apply_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(error) |-> !phaseApply);

endmodule

// File: rtl/sample_phase_tuner.sv
module sample_phase_tuner
  import sweep_pkg::*;
#(
  parameter int NSTEPS   = 32,
  parameter int MAX_DEG  = 270,
  parameter int MAX_RUNS = 17,
  parameter int DEGW     = 9
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            start,
  input  logic            tuneDone,
  input  logic            tunePass,
  output logic            tuneReq,
  output logic            phaseApply,
  output logic [DEGW-1:0] phaseOut,
  output logic            busy,
  output logic            done,
  output logic            error,
  output logic [DEGW-1:0] finalPhase
);
  ctrlStrobes_t ctl;
  sweepStatus_t stat;

  sweep_control u_ctrl (
    .clk(clk), .rst(rst), .start(start), .tuneDone(tuneDone), .stat(stat),
    .ctl(ctl), .tuneReq(tuneReq), .phaseApply(phaseApply), .busy(busy),
    .done(done), .error(error)
  );

  sweep_datapath #(
    .NSTEPS(NSTEPS), .MAX_DEG(MAX_DEG), .MAX_RUNS(MAX_RUNS), .DEGW(DEGW)
  ) u_dp (
    .clk(clk), .rst(rst), .ctl(ctl), .tunePass(tunePass), .stat(stat),
    .phaseOut(phaseOut), .finalPhase(finalPhase)
  );

endmodule

// File: tb/sample_phase_tuner_test.sv
`timescale 1ns/1ps
module sample_phase_tuner_test;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       start = 1'b0;
  logic       tuneDone = 1'b0;
  logic       tunePass = 1'b0;
  logic       tuneReq, phaseApply, busy, done, error;
  logic [8:0] phaseOut, finalPhase;

  int nChecks = 0;
  int nErr    = 0;

  always #2 clk = ~clk;

  sample_phase_tuner uut (
    .clk(clk), .rst(rst), .start(start), .tuneDone(tuneDone), .tunePass(tunePass),
    .tuneReq(tuneReq), .phaseApply(phaseApply), .phaseOut(phaseOut), .busy(busy),
    .done(done), .error(error), .finalPhase(finalPhase)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nErr++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int degOf(input int i);
    return (i * 45 + 3) / 4;
  endfunction

  // Reference model of the selection rules
  task automatic refTune(input logic [24:0] pat, output bit err, output int ph);
    int rs[20];
    int re[20];
    int n, b, bl, mid, len;
    bit prev;
    n = 0; prev = 0; b = 0; bl = -1;
    for (int i = 0; i < 25; i++) begin
      if (pat[i] && !prev) begin rs[n] = i; n++; end
      if (pat[i]) re[n-1] = i;
      prev = pat[i];
    end
    err = (n == 0);
    ph  = 0;
    if (err) return;
    if (n > 1 && pat[0] && pat[24]) begin rs[0] = rs[n-1]; n--; end
    for (int k = 0; k < n; k++) begin
      len = re[k] - rs[k] + 1;
      if (len < 0) len += 32;
      if (len > bl) begin bl = len; b = k; end
    end
    mid = (rs[b] + bl / 2) % 32;
    ph  = degOf(mid);
    if (ph > 270) ph = (ph < 315) ? 270 : 0;
  endtask

  task automatic runOne(input logic [24:0] pat, input bit inject, input string tag);
    bit expErr, fin, injected, prevApply;
    int expPh, applyCount, dly;
    refTune(pat, expErr, expPh);
    fin = 0; injected = 0; prevApply = 0; applyCount = 0; dly = 0;
    for (int c = 0; c < 3000 && !fin; c++) begin
      @(negedge clk);
      start = 1'b0;
      if (c == 0) start = 1'b1;
      else if (inject && !injected && applyCount == 10) begin
        start = 1'b1; injected = 1;
      end
      if (phaseApply) begin
        chk(!prevApply, "R3 apply width", 2, 1);
        if (applyCount < 25) chk(phaseOut == degOf(applyCount), "R2 step phase",
                                 int'(phaseOut), degOf(applyCount));
        else chk(phaseOut == expPh, {tag, " R10 applied"}, int'(phaseOut), expPh);
        applyCount++;
      end
      prevApply = phaseApply;
      if (tuneDone) begin
        tuneDone = 1'b0;
      end else if (tuneReq) begin
        if (dly == 0) begin
          tuneDone = 1'b1;
          tunePass = (applyCount > 0) ? pat[applyCount-1] : 1'b0;
          dly = $urandom % 4;
        end else dly--;
      end
      if (done) begin
        fin = 1;
        chk(error == expErr, {tag, " R5 error"}, int'(error), int'(expErr));
        if (!expErr) chk(finalPhase == expPh, {tag, " R8 R9 final"}, int'(finalPhase), expPh);
        chk(applyCount == (expErr ? 25 : 26), {tag, " R11 apply count"},
            applyCount, expErr ? 25 : 26);
      end
    end
    if (!fin) chk(0, {tag, " watchdog"}, 0, 1);
    tuneDone = 1'b0;
    start = 1'b0;
    @(negedge clk);
    chk(!busy && !done, "R10 idle after done", int'(busy), 0);
  endtask

  initial begin
    logic [24:0] p;
    void'($urandom(32'd4711));
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1
    chk(!busy && !done && !error && !tuneReq && !phaseApply, "R1 reset controls",
        {busy, done, error, tuneReq, phaseApply}, 0);
    chk(finalPhase == 0 && phaseOut == 0, "R1 reset phase", int'(finalPhase), 0);

    runOne(25'h0, 0, "R5 all fail");
    runOne(25'h1FFFFFF, 0, "R4 all pass");
    runOne(25'h1, 0, "R4 step0 only");
    runOne(25'h1F0000F, 0, "R6 wrap to 0");
    runOne(25'h1FC0001, 0, "R6 wrap to 270");
    runOne(25'h000381C, 0, "R7 tie");
    runOne(25'h1000000, 0, "R4 last only");
    runOne(25'h0F0F0F0, 1, "R11 inject");
    for (int k = 0; k < 40; k++) begin
      p = 25'($urandom);
      if (k % 3 == 0) p = p & 25'($urandom);
      if (k % 4 == 1) p = p | 25'h1000001;
      runOne(p, (k % 5 == 0), "R7 random");
    end
    $display("Result: errors=%0d of %0d checks", nErr, nChecks);
    $finish;
  end
endmodule